// File: doc/BRIEF.md
# Secure Debug Access Controller

This block decides whether an external debugger may reach the chip's debug resources. A 2-bit fused mode selects one of four policies. Open grants access at once. Locked refuses it for good. The two conditional modes hold access closed until the debugger proves knowledge of a fused 64-bit response. In the conditional modes the block shows a fused 64-bit challenge. The debugger loads its 64-bit answer as two 32-bit halves and then strobes a submit. The block compares the answer with the fused response word.

The two conditional modes differ only in what happens on a pass. The silent variant opens debug straight away. The notifying variant first raises a notice to the security monitor. It also requests that ephemeral secrets be wiped and that persistent secrets be locked out. Debug opens only after both of those requests are acknowledged. Wrong answers are counted. The third one locks the exchange until reset and sends a one-cycle violation pulse to the security monitor. Boundary-scan access stays available whatever the mode.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: `mode_fuse` encodes 2'b00 = open, 2'b01 = conditional silent, 2'b10 = conditional with notice, 2'b11 = locked. In open mode `dbg_en` is high from the first clock edge after reset is released, and no challenge is required.
- R2: In locked mode `dbg_en` never rises, even after a correct response is submitted.
- R3: `bscan_en` is high from the first clock edge after reset is released, in all four modes.
- R4: In the two conditional modes `challenge_out` carries `chal_fuse`, registered one edge. In open and locked modes it reads zero.
- R5: `wr_lo` loads `wr_data` into response bits 31:0 and `wr_hi` loads it into bits 63:32. A `submit` is an attempt only if both halves were loaded since the previous submit. Every submit discards the loaded halves. A submit after only one half was loaded neither passes nor counts as a failure.
- R6: In silent mode a correct attempt raises `dbg_en` one edge after the edge that samples `submit`. `notify`, `eph_clr_req` and `pers_lock_req` stay low.
- R7: In notice mode a correct attempt raises `notify`, `eph_clr_req` and `pers_lock_req` at the submit edge. Each request stays high until its acknowledge (`clr_ack` or `lock_ack`) is sampled, and drops at that edge. `dbg_en` rises one edge after the edge at which both acknowledges have been seen. `notify` stays high while access is granted.
- R8: Wrong attempts are counted. The third wrong attempt raises `viol_pulse` for exactly one cycle, starting at that submit edge.
- R9: After lockout every later submit is ignored, including a correct one: there is no access and no further violation. Only reset clears the count and the lockout.
- R10: After fewer than three wrong attempts, a correct attempt still grants access.
- R11: In open and locked modes, submits (right or wrong) never raise `viol_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fuse | input | 2 | Fused access policy |
| chal_fuse | input | 64 | Fused challenge value |
| resp_fuse | input | 64 | Fused expected response |
| wr_lo | input | 1 | Load low response half |
| wr_hi | input | 1 | Load high response half |
| wr_data | input | 32 | Response half data |
| submit | input | 1 | Submit loaded response |
| clr_ack | input | 1 | Ephemeral wipe acknowledge |
| lock_ack | input | 1 | Persistent lockout acknowledge |
| challenge_out | output | 64 | Presented challenge |
| dbg_en | output | 1 | Debug access enable |
| bscan_en | output | 1 | Boundary-scan enable |
| viol_pulse | output | 1 | Security violation pulse |
| notify | output | 1 | Active-debug notice to security monitor |
| eph_clr_req | output | 1 | Ephemeral secret wipe request |
| pers_lock_req | output | 1 | Persistent secret lockout request |

## Verification
The violation pulse and the notice and request outputs change at the same edge that samples the submit strobe or the acknowledge. `dbg_en` follows one edge later, because it is registered from the access state. The bench drives every input on the falling edge. It reads violation and request outputs at the falling edge right after the submit edge, and reads `dbg_en` one falling edge further on. Results that are claimed to be ignored, such as post-lockout submissions, partial loads and submissions in open or locked modes, are checked on `viol_pulse` and `dbg_en` at those same points.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN        = 2'b00,
    MODE_COND_SILENT = 2'b01,
    MODE_COND_NOTIFY = 2'b10,
    MODE_LOCKED      = 2'b11
  } dbg_mode_e;

  typedef enum logic [1:0] {
    ST_BLOCK  = 2'b00,
    ST_NOTIFY = 2'b01,
    ST_GRANT  = 2'b10
  } acc_state_e;
endpackage

// File: rtl/resp_loader.sv
module resp_loader #(
  parameter int HALF_W = 32,
  parameter int PARTS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    consume,
  input  logic [PARTS-1:0]        wr_part,
  input  logic [HALF_W-1:0]       wr_data,
  output logic [HALF_W*PARTS-1:0] resp_word,
  output logic                    full
);
  logic [PARTS-1:0] vld;

  for (genvar g = 0; g < PARTS; g++) begin : g_seg
    logic [HALF_W-1:0] seg;
    always_ff @(posedge clk) begin
      if (rst) begin
        seg    <= '0;
        vld[g] <= 1'b0;
      end else if (consume) begin
        vld[g] <= 1'b0;
      end else if (enable && wr_part[g]) begin
        seg    <= wr_data;
        vld[g] <= 1'b1;
      end
    end
    assign resp_word[g*HALF_W +: HALF_W] = seg;
  end

  assign full = &vld;
endmodule

// File: rtl/fail_tracker.sv
module fail_tracker #(
  parameter int MAX_FAILS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic attempt,
  input  logic pass,
  output logic locked_out,
  output logic viol_pulse
);
  localparam int CNT_W = $clog2(MAX_FAILS + 1);

  logic [CNT_W-1:0] fails;

  always_ff @(posedge clk) begin
    if (rst) begin
      fails      <= '0;
      locked_out <= 1'b0;
      viol_pulse <= 1'b0;
    end else begin
      viol_pulse <= 1'b0;
      if (attempt && !pass && !locked_out) begin
        fails <= fails + 1'b1;
        if (fails == CNT_W'(MAX_FAILS - 1)) begin
          locked_out <= 1'b1;
          viol_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/access_fsm.sv
module access_fsm
  import dbg_gate_pkg::*;
#(
  parameter int CHAL_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  dbg_mode_e         mode,
  input  logic              attempt,
  input  logic              pass,
  input  logic              clr_ack,
  input  logic              lock_ack,
  input  logic [CHAL_W-1:0] chal_fuse,
  output logic              waiting,
  output logic [CHAL_W-1:0] challenge_out,
  output logic              dbg_en,
  output logic              bscan_en,
  output logic              notify,
  output logic              eph_clr_req,
  output logic              pers_lock_req
);
  acc_state_e state;
  logic       got_clr, got_lock, cond;

  assign cond    = (mode == MODE_COND_SILENT) || (mode == MODE_COND_NOTIFY);
  assign waiting = (state == ST_BLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_BLOCK;
      got_clr       <= 1'b0;
      got_lock      <= 1'b0;
      notify        <= 1'b0;
      eph_clr_req   <= 1'b0;
      pers_lock_req <= 1'b0;
      dbg_en        <= 1'b0;
      bscan_en      <= 1'b0;
      challenge_out <= '0;
    end else begin
      bscan_en      <= 1'b1;
      challenge_out <= cond ? chal_fuse : '0;
      dbg_en        <= (mode == MODE_OPEN) || (cond && state == ST_GRANT);
      case (state)
        ST_BLOCK: begin
          if (attempt && pass) begin
            if (mode == MODE_COND_NOTIFY) begin
              state         <= ST_NOTIFY;
              notify        <= 1'b1;
              eph_clr_req   <= 1'b1;
              pers_lock_req <= 1'b1;
              got_clr       <= 1'b0;
              got_lock      <= 1'b0;
            end else begin
              state <= ST_GRANT;
            end
          end
        end
        ST_NOTIFY: begin
          if (clr_ack) begin
            eph_clr_req <= 1'b0;
            got_clr     <= 1'b1;
          end
          if (lock_ack) begin
            pers_lock_req <= 1'b0;
            got_lock      <= 1'b1;
          end
          if ((got_clr || clr_ack) && (got_lock || lock_ack)) state <= ST_GRANT;
        end
        default: state <= ST_GRANT;
      endcase
    end
  end
endmodule

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
  import dbg_gate_pkg::*;
#(
  parameter int HALF_W    = 32,
  parameter int PARTS     = 2,
  parameter int MAX_FAILS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_fuse,
  input  logic [HALF_W*PARTS-1:0] chal_fuse,
  input  logic [HALF_W*PARTS-1:0] resp_fuse,
  input  logic                    wr_lo,
  input  logic                    wr_hi,
  input  logic [HALF_W-1:0]       wr_data,
  input  logic                    submit,
  input  logic                    clr_ack,
  input  logic                    lock_ack,
  output logic [HALF_W*PARTS-1:0] challenge_out,
  output logic                    dbg_en,
  output logic                    bscan_en,
  output logic                    viol_pulse,
  output logic                    notify,
  output logic                    eph_clr_req,
  output logic                    pers_lock_req
);
  localparam int WORD_W = HALF_W * PARTS;

  dbg_mode_e         mode;
  logic [WORD_W-1:0] resp_word;
  logic              full, pass, attempt, waiting, locked_out, cond;
  logic [PARTS-1:0]  wr_part;

  assign mode = dbg_mode_e'(mode_fuse);
  assign cond = (mode == MODE_COND_SILENT) || (mode == MODE_COND_NOTIFY);

  always_comb begin
    wr_part    = '0;
    wr_part[0] = wr_lo;
    wr_part[PARTS-1] = wr_part[PARTS-1] | wr_hi;
  end

  assign pass    = (resp_word == resp_fuse);
  assign attempt = submit && full && cond && waiting && !locked_out;

  resp_loader #(.HALF_W(HALF_W), .PARTS(PARTS)) u_load (
    .clk(clk), .rst(rst), .enable(!locked_out), .consume(submit),
    .wr_part(wr_part), .wr_data(wr_data), .resp_word(resp_word), .full(full)
  );

  fail_tracker #(.MAX_FAILS(MAX_FAILS)) u_fail (
    .clk(clk), .rst(rst), .attempt(attempt), .pass(pass),
    .locked_out(locked_out), .viol_pulse(viol_pulse)
  );

  access_fsm #(.CHAL_W(WORD_W)) u_fsm (
    .clk(clk), .rst(rst), .mode(mode), .attempt(attempt), .pass(pass),
    .clr_ack(clr_ack), .lock_ack(lock_ack), .chal_fuse(chal_fuse),
    .waiting(waiting), .challenge_out(challenge_out), .dbg_en(dbg_en),
    .bscan_en(bscan_en), .notify(notify), .eph_clr_req(eph_clr_req),
    .pers_lock_req(pers_lock_req)
  );
endmodule

// File: rtl/dbg_gate_chk.sv
module dbg_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_fuse,
  input logic       dbg_en,
  input logic       bscan_en,
  input logic       viol_pulse,
  input logic       notify,
  input logic       eph_clr_req,
  input logic       pers_lock_req,
  input logic       clr_ack,
  input logic       lock_ack
);
  p_locked_closed_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_fuse == 2'b11 && $past(mode_fuse) == 2'b11) |-> !dbg_en);

  p_bscan_on_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bscan_en);

  p_silent_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    mode_fuse == 2'b01 |-> (!notify && !eph_clr_req && !pers_lock_req));

  p_grant_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_fuse == 2'b10 && $rose(dbg_en)) |-> (notify && $past(!eph_clr_req && !pers_lock_req)));

  p_clr_held_r7: assert property (@(posedge clk) disable iff (rst)
    (eph_clr_req && !clr_ack) |=> eph_clr_req);

  p_lock_held_r7: assert property (@(posedge clk) disable iff (rst)
    (pers_lock_req && !lock_ack) |=> pers_lock_req);

  p_viol_single_r8: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |=> !viol_pulse);
endmodule

bind dbg_gate_ctrl dbg_gate_chk u_chk (
  .clk(clk), .rst(rst), .mode_fuse(mode_fuse), .dbg_en(dbg_en),
  .bscan_en(bscan_en), .viol_pulse(viol_pulse), .notify(notify),
  .eph_clr_req(eph_clr_req), .pers_lock_req(pers_lock_req),
  .clr_ack(clr_ack), .lock_ack(lock_ack)
);

// File: tb/tb_dbg_gate_ctrl.sv
module tb_dbg_gate_ctrl;
  localparam logic [63:0] CHAL = 64'hC0FF_EE00_1234_5678;
  localparam logic [63:0] GOOD = 64'hA5A5_0F0F_DEAD_BEEF;

  logic        clk = 1'b0, rst = 1'b1;
  logic [1:0]  mode_fuse = 2'b00;
  logic        wr_lo = 0, wr_hi = 0, submit = 0, clr_ack = 0, lock_ack = 0;
  logic [31:0] wr_data = '0;
  logic [63:0] challenge_out;
  logic        dbg_en, bscan_en, viol_pulse, notify, eph_clr_req, pers_lock_req;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dbg_gate_ctrl dut (
    .clk(clk), .rst(rst), .mode_fuse(mode_fuse), .chal_fuse(CHAL), .resp_fuse(GOOD),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .submit(submit),
    .clr_ack(clr_ack), .lock_ack(lock_ack), .challenge_out(challenge_out),
    .dbg_en(dbg_en), .bscan_en(bscan_en), .viol_pulse(viol_pulse), .notify(notify),
    .eph_clr_req(eph_clr_req), .pers_lock_req(pers_lock_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk); rst = 1'b1; mode_fuse = m;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // loads selected halves, then submits; returns at the falling edge after the submit edge
  task automatic send(input logic [63:0] v, input bit do_lo, input bit do_hi);
    if (do_lo) begin wr_lo = 1; wr_data = v[31:0]; @(negedge clk); wr_lo = 0; end
    if (do_hi) begin wr_hi = 1; wr_data = v[63:32]; @(negedge clk); wr_hi = 0; end
    submit = 1; @(negedge clk); submit = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset dbg_en", {63'd0, dbg_en}, 64'd0);
    chk("reset viol", {63'd0, viol_pulse}, 64'd0);
    chk("reset bscan", {63'd0, bscan_en}, 64'd0);

    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      chk("R1 dbg_en after reset", {63'd0, dbg_en}, {63'd0, m == 0});
      chk("R3 bscan_en", {63'd0, bscan_en}, 64'd1);
      chk("R4 challenge", challenge_out, (m == 1 || m == 2) ? CHAL : 64'd0);
      send(64'h1111_2222_3333_4444, 1, 1);
      if (m == 0 || m == 3) chk("R11 wrong no viol", {63'd0, viol_pulse}, 64'd0);
      send(GOOD, 1, 1);
      if (m == 0 || m == 3) chk("R11 good no viol", {63'd0, viol_pulse}, 64'd0);
      if (m == 2) begin
        chk("R7 notify", {63'd0, notify}, 64'd1);
        chk("R7 eph req", {63'd0, eph_clr_req}, 64'd1);
        chk("R7 pers req", {63'd0, pers_lock_req}, 64'd1);
      end
      @(negedge clk);
      case (m)
        0: chk("R1 open dbg_en", {63'd0, dbg_en}, 64'd1);
        1: begin
          chk("R6 silent dbg_en", {63'd0, dbg_en}, 64'd1);
          chk("R6 silent no notify", {61'd0, notify, eph_clr_req, pers_lock_req}, 64'd0);
        end
        2: begin
          chk("R7 no access before acks", {63'd0, dbg_en}, 64'd0);
          clr_ack = 1; @(negedge clk); clr_ack = 0;
          chk("R7 eph req drops", {63'd0, eph_clr_req}, 64'd0);
          chk("R7 pers req held", {63'd0, pers_lock_req}, 64'd1);
          repeat (3) @(negedge clk);
          chk("R7 still closed one ack", {63'd0, dbg_en}, 64'd0);
          lock_ack = 1; @(negedge clk); lock_ack = 0;
          chk("R7 pers req drops", {63'd0, pers_lock_req}, 64'd0);
          chk("R7 closed at ack edge", {63'd0, dbg_en}, 64'd0);
          @(negedge clk);
          chk("R7 dbg_en after acks", {63'd0, dbg_en}, 64'd1);
          chk("R7 notify held", {63'd0, notify}, 64'd1);
        end
        default: chk("R2 locked dbg_en", {63'd0, dbg_en}, 64'd0);
      endcase
    end

    // partial loads never count
    do_reset(2'b01);
    for (int i = 0; i < 4; i++) begin
      send(64'h0, i[0], !i[0]);
      chk("R5 partial no viol", {63'd0, viol_pulse}, 64'd0);
    end
    send(GOOD, 0, 1);
    @(negedge clk);
    chk("R5 partial good not accepted", {63'd0, dbg_en}, 64'd0);
    // two wrong (low half wrong, high half wrong), then correct
    send({GOOD[63:32], ~GOOD[31:0]}, 1, 1);
    chk("R10 wrong lo no viol", {63'd0, viol_pulse}, 64'd0);
    send({~GOOD[63:32], GOOD[31:0]}, 1, 1);
    chk("R10 wrong hi no viol", {63'd0, viol_pulse}, 64'd0);
    send(GOOD, 1, 1);
    @(negedge clk);
    chk("R10 access after two fails", {63'd0, dbg_en}, 64'd1);

    // three fails lock the exchange
    do_reset(2'b01);
    for (int i = 0; i < 3; i++) begin
      send(GOOD ^ (64'd1 << (i * 20)), 1, 1);
      chk("R8 viol on third only", {63'd0, viol_pulse}, {63'd0, i == 2});
    end
    @(negedge clk);
    chk("R8 viol one cycle", {63'd0, viol_pulse}, 64'd0);
    send(GOOD, 1, 1);
    chk("R9 no viol after lock", {63'd0, viol_pulse}, 64'd0);
    @(negedge clk);
    chk("R9 good ignored", {63'd0, dbg_en}, 64'd0);
    send(64'h5, 1, 1);
    chk("R9 wrong ignored", {63'd0, viol_pulse}, 64'd0);
    do_reset(2'b01);
    send(GOOD, 1, 1);
    @(negedge clk);
    chk("R9 reset clears lock", {63'd0, dbg_en}, 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule